// File: doc/BRIEF.md
# Processor Run Control Register Block

This block sits beside a cluster of up to 64 virtual processors and decides which of them execute. Software writes a bit mask to a start register or a stop register. Only processors whose state really changes are acted on. A processor that is newly started gets a one-cycle reset pulse, and a processor that is newly stopped gets a one-cycle halt pulse. A single bitmap records which processors are running, and software can read it back.

The same three registers can be reached through two aliased address windows. One window is for local cluster accesses and the other for accesses made on behalf of another core. The processor count and the set of processors brought up automatically after reset are elaboration parameters. The access port is a plain valid/address/data register port.

Top module: `vp_run_ctrl`

## Requirements
- R1: Only data bits below NUM_VP take part in a start or stop write; data bits at or above NUM_VP change nothing.
- R2: A start write produces a reset pulse only for processors whose data bit is 1 and which are not running, and it marks exactly those processors as running.
- R3: A stop write produces a halt pulse only for processors whose data bit is 1 and which are running, and it marks exactly those processors as stopped.
- R4: The reset and halt pulses are high for exactly one clock cycle, the cycle after the write is sampled. The bitmap takes its new value in the same cycle, and the two pulses are never high together for one processor.
- R5: A read of the status register returns the running bitmap in bits [NUM_VP-1:0], with zeros above it. The read data is combinational, so a read in the same cycle as a write returns the bitmap from before that write.
- R6: There are two windows, at base 0x2000 and base 0x4000. In each window, start is at offset 0x28, stop is at offset 0x30 and status is at offset 0x70. Address bits [2:0] are ignored, so the decode works on 8-byte words.
- R7: A read of any address other than the two status words returns zero. A write to any address other than the start and stop words changes neither the bitmap nor the pulses.
- R8: While reset is held, the bitmap is zero and no pulse is raised. On the first clock edge after release, START_RUNNING is applied as a start command, so each processor in it gets a reset pulse. NUM_VP outside 1..64, or a START_RUNNING outside the processor mask, stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_valid | input | 1 | Write strobe, sampled on the rising edge |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 64 | Write data (processor mask) |
| rd_valid | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 64 | Read data, combinational |
| vp_reset_pulse | output | NUM_VP | One-cycle reset pulse per processor |
| vp_halt_pulse | output | NUM_VP | One-cycle halt pulse per processor |

## Verification
The bench issues start commands that overlap processors already running, and stop commands that name processors already stopped. A design that pulsed on every set bit would show spurious reset or halt pulses there. The bench writes data whose only set bits lie above the processor count, uses the second window and the misaligned byte addresses inside an 8-byte word, and targets the status word and empty space with writes. A decoder that is too loose or too strict would then change the bitmap or miss the command. The bench also checks that each pulse drops after one cycle, that the boot mask is pulsed on the first edge after reset, and that a read in the same cycle as a write sees the old bitmap rather than the new one.

// File: rtl/vp_run_ctrl_pkg.sv
package vp_run_ctrl_pkg;

   localparam int REG_W   = 64;
   localparam int NUM_WIN = 2;

   localparam int OFS_START  = 'h28;
   localparam int OFS_STOP   = 'h30;
   localparam int OFS_STATUS = 'h70;

   typedef enum logic [1:0] {
      REG_NONE   = 2'd0,
      REG_START  = 2'd1,
      REG_STOP   = 2'd2,
      REG_STATUS = 2'd3
   } vp_reg_e;

   function automatic int win_base(int w);
      return (w == 0) ? 'h2000 : 'h4000;
   endfunction

endpackage

// File: rtl/vp_reg_decode.sv
module vp_reg_decode
   import vp_run_ctrl_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              valid,
   input  logic [ADDR_W-1:0] addr,
   output vp_reg_e           kind
);

   if (ADDR_W < 15 || ADDR_W > 32) begin : g_bad_addr_w
      $error("vp_reg_decode: ADDR_W must lie in 15..32");
   end

   logic [NUM_WIN-1:0] hit_start;
   logic [NUM_WIN-1:0] hit_stop;
   logic [NUM_WIN-1:0] hit_status;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      localparam logic [ADDR_W-1:0] A_START  = ADDR_W'(win_base(w) + OFS_START);
      localparam logic [ADDR_W-1:0] A_STOP   = ADDR_W'(win_base(w) + OFS_STOP);
      localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(win_base(w) + OFS_STATUS);
      assign hit_start[w]  = (addr[ADDR_W-1:3] == A_START[ADDR_W-1:3]);
      assign hit_stop[w]   = (addr[ADDR_W-1:3] == A_STOP[ADDR_W-1:3]);
      assign hit_status[w] = (addr[ADDR_W-1:3] == A_STATUS[ADDR_W-1:3]);
   end

   logic unused_low;
   assign unused_low = ^addr[2:0];

   always_comb begin
      kind = REG_NONE;
      if (valid) begin
         if (|hit_start)       kind = REG_START;
         else if (|hit_stop)   kind = REG_STOP;
         else if (|hit_status) kind = REG_STATUS;
      end
   end

endmodule

// File: rtl/vp_slice.sv
module vp_slice (
   input  logic clk,
   input  logic rst_n,
   input  logic start_req,
   input  logic stop_req,
   output logic running,
   output logic rst_pulse,
   output logic halt_pulse
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running    <= 1'b0;
         rst_pulse  <= 1'b0;
         halt_pulse <= 1'b0;
      end else begin
         rst_pulse  <= start_req & ~running;
         halt_pulse <= stop_req & ~start_req & running;
         if (start_req)     running <= 1'b1;
         else if (stop_req) running <= 1'b0;
      end
   end

   p_start_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse |-> (running && !$past(running)));

   p_stop_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
      halt_pulse |-> (!running && $past(running)));

   p_pulse_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(rst_pulse && halt_pulse));

   p_reset_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse |=> !rst_pulse);

   p_halt_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      halt_pulse |=> !halt_pulse);

endmodule

// File: rtl/vp_run_ctrl.sv
module vp_run_ctrl
   import vp_run_ctrl_pkg::*;
#(
   parameter int          NUM_VP        = 1,
   parameter logic [63:0] START_RUNNING = 64'h1,
   parameter int          ADDR_W        = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [63:0]       wr_data,
   input  logic              rd_valid,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [63:0]       rd_data,
   output logic [NUM_VP-1:0] vp_reset_pulse,
   output logic [NUM_VP-1:0] vp_halt_pulse
);

   localparam logic [REG_W-1:0] VP_MASK =
      (NUM_VP >= REG_W) ? {REG_W{1'b1}} : ((64'd1 << NUM_VP) - 64'd1);
   localparam logic [NUM_VP-1:0] BOOT_SET = START_RUNNING[NUM_VP-1:0];

   if (NUM_VP < 1 || NUM_VP > REG_W) begin : g_bad_num_vp
      $error("vp_run_ctrl: NUM_VP must lie in 1..64");
   end
   if ((START_RUNNING & ~VP_MASK) != 64'd0) begin : g_bad_start
      $error("vp_run_ctrl: START_RUNNING names a processor beyond NUM_VP");
   end

   vp_reg_e wr_kind;
   vp_reg_e rd_kind;

   vp_reg_decode #(.ADDR_W(ADDR_W)) i_wr_dec (
      .valid (wr_valid),
      .addr  (wr_addr),
      .kind  (wr_kind)
   );

   vp_reg_decode #(.ADDR_W(ADDR_W)) i_rd_dec (
      .valid (rd_valid),
      .addr  (rd_addr),
      .kind  (rd_kind)
   );

   logic boot_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) boot_q <= 1'b1;
      else        boot_q <= 1'b0;
   end

   logic [NUM_VP-1:0] data_vp;
   logic [NUM_VP-1:0] start_vec;
   logic [NUM_VP-1:0] stop_vec;
   logic [NUM_VP-1:0] run_vec;

   assign data_vp   = wr_data[NUM_VP-1:0];
   assign start_vec = ((wr_kind == REG_START) ? data_vp : '0) | (boot_q ? BOOT_SET : '0);
   assign stop_vec  = (wr_kind == REG_STOP) ? data_vp : '0;

   logic unused_hi;
   assign unused_hi = ^wr_data;

   for (genvar v = 0; v < NUM_VP; v++) begin : g_vp
      vp_slice i_slice (
         .clk        (clk),
         .rst_n      (rst_n),
         .start_req  (start_vec[v]),
         .stop_req   (stop_vec[v]),
         .running    (run_vec[v]),
         .rst_pulse  (vp_reset_pulse[v]),
         .halt_pulse (vp_halt_pulse[v])
      );
   end

   assign rd_data = (rd_kind == REG_STATUS) ? REG_W'(run_vec) : '0;

   p_unmapped_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_kind == REG_NONE && !boot_q) |=>
         ($stable(run_vec) && vp_reset_pulse == '0 && vp_halt_pulse == '0));

   p_unmapped_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_kind != REG_STATUS) |-> (rd_data == '0));

   p_boot_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(boot_q) |-> ((vp_reset_pulse & BOOT_SET) == BOOT_SET));

endmodule

// File: tb/test_vp_run_ctrl.sv
module test_vp_run_ctrl;

   localparam int          NV    = 8;
   localparam logic [63:0] START = 64'h05;

   typedef struct packed {
      logic [15:0] waddr;
      logic [63:0] wdata;
      logic [15:0] raddr;
      logic [7:0]  exp_rst;
      logic [7:0]  exp_halt;
      logic [7:0]  exp_map;
   } vec_t;

   localparam int NVEC = 11;
   localparam vec_t VECS [NVEC] = '{
      '{16'h2028, 64'h0F,                  16'h2070, 8'h0A, 8'h00, 8'h0F}, // R2 partial overlap
      '{16'h4028, 64'h0F,                  16'h4070, 8'h00, 8'h00, 8'h0F}, // R2 all running, R6
      '{16'h2030, 64'h03,                  16'h2074, 8'h00, 8'h03, 8'h0C}, // R3
      '{16'h4030, 64'h33,                  16'h4070, 8'h00, 8'h00, 8'h0C}, // R3 already stopped
      '{16'h4028, 64'hFFFF_FF00_0000_0100, 16'h2070, 8'h00, 8'h00, 8'h0C}, // R1 high bits only
      '{16'h4028, 64'hF0,                  16'h4070, 8'hF0, 8'h00, 8'hFC}, // R2 second window
      '{16'h2070, 64'hFF,                  16'h2070, 8'h00, 8'h00, 8'hFC}, // R7 status not writable
      '{16'h3028, 64'hFF,                  16'h4070, 8'h00, 8'h00, 8'hFC}, // R7 empty space
      '{16'h202C, 64'h01,                  16'h2070, 8'h01, 8'h00, 8'hFD}, // R6 bits [2:0] ignored
      '{16'h4034, 64'hFF,                  16'h4070, 8'h00, 8'hFD, 8'h00}, // R3 R6
      '{16'h2028, 64'hFF,                  16'h2070, 8'hFF, 8'h00, 8'hFF}  // R2 all
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_valid;
   logic [15:0] wr_addr;
   logic [63:0] wr_data;
   logic        rd_valid;
   logic [15:0] rd_addr;
   logic [63:0] rd_data;
   logic [NV-1:0] vp_reset_pulse;
   logic [NV-1:0] vp_halt_pulse;

   always #4 clk = ~clk;

   vp_run_ctrl #(.NUM_VP(NV), .START_RUNNING(START), .ADDR_W(16)) i_vp_run_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .wr_valid       (wr_valid),
      .wr_addr        (wr_addr),
      .wr_data        (wr_data),
      .rd_valid       (rd_valid),
      .rd_addr        (rd_addr),
      .rd_data        (rd_data),
      .vp_reset_pulse (vp_reset_pulse),
      .vp_halt_pulse  (vp_halt_pulse)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [15:0] a, output logic [63:0] v);
      rd_valid = 1'b1;
      rd_addr  = a;
      #1;
      v = rd_data;
      rd_valid = 1'b0;
   endtask

   task automatic wr_start(input logic [15:0] a, input logic [63:0] d);
      @(negedge clk);
      wr_valid = 1'b1;
      wr_addr  = a;
      wr_data  = d;
      @(posedge clk);
      #1;
      wr_valid = 1'b0;
   endtask

   initial begin
      logic [63:0] v;
      rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
      rd_valid = 1'b0; rd_addr = '0;
      repeat (3) @(posedge clk);
      #2;
      rd(16'h2070, v);
      chk("R8 bitmap in reset", v, 64'h0);
      chk("R8 no pulse in reset", {vp_reset_pulse, vp_halt_pulse}, 64'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk("R8 boot reset pulse", vp_reset_pulse, 64'h05);
      chk("R8 boot no halt", vp_halt_pulse, 64'h0);
      rd(16'h4070, v);
      chk("R8 boot bitmap", v, 64'h05);
      @(posedge clk);
      #1;
      chk("R4 boot pulse one cycle", vp_reset_pulse, 64'h0);

      for (int i = 0; i < NVEC; i++) begin
         wr_start(VECS[i].waddr, VECS[i].wdata);
         chk($sformatf("R1 R2 R3 R6 R7 vec %0d reset pulse", i), vp_reset_pulse, VECS[i].exp_rst);
         chk($sformatf("R1 R2 R3 R6 R7 vec %0d halt pulse", i), vp_halt_pulse, VECS[i].exp_halt);
         rd(VECS[i].raddr, v);
         chk($sformatf("R5 vec %0d bitmap", i), v, 64'(VECS[i].exp_map));
         @(posedge clk);
         #1;
         chk($sformatf("R4 vec %0d pulses drop", i), {vp_reset_pulse, vp_halt_pulse}, 64'h0);
      end

      rd(16'h2028, v);
      chk("R7 read of start word", v, 64'h0);
      rd(16'h6070, v);
      chk("R7 read outside windows", v, 64'h0);
      rd(16'h4030, v);
      chk("R7 read of stop word", v, 64'h0);
      rd(16'h4077, v);
      chk("R6 read status last byte", v, 64'hFF);

      @(negedge clk);
      wr_valid = 1'b1; wr_addr = 16'h2030; wr_data = 64'hFF;
      rd(16'h4070, v);
      chk("R5 same-cycle read sees old bitmap", v, 64'hFF);
      @(posedge clk);
      #1;
      wr_valid = 1'b0;
      chk("R3 stop all halt pulse", vp_halt_pulse, 64'hFF);
      rd(16'h2070, v);
      chk("R5 bitmap after stop all", v, 64'h0);

      @(posedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule